// File: doc/BRIEF.md
# Cascadable Priority Encoder Tree

This block finds the highest-numbered active line in a 32-bit request vector and reports its 5-bit position. It is built as a tree. Four identical 8-input encoder slices each cover one byte-wide group of requests. Each slice has an enable input and two flags. The empty flag is high when the slice is enabled and none of its inputs is set. The hit flag is high when the slice is enabled and at least one input is set.

The slices are chained from the top group down. The global enable drives the slice for bits 31..24. Each slice's empty flag then enables the slice for the next lower group, so a lower group is looked at only while every higher group is empty. The low three bits of the result are the OR of the slices' local indices. This works because a disabled slice drives index 0. The two upper bits are the group number of the slice that reports a hit.

The block is purely combinational. A caller applies a request vector and an enable, and reads the index, the combined hit flag and the final empty flag in the same cycle.

Top module: `pe_tree`

## Requirements
- R1: With `en`=1 and at least one request set, `index` equals the highest bit position n for which `req[n]`=1.
- R2: `hit` is 1 exactly when `en`=1 and `req` is not all zero.
- R3: `empty` is 1 exactly when `en`=1 and `req` is all zero.
- R4: With `en`=0, `index`, `hit` and `empty` are all 0, whatever `req` holds.
- R5: With `en`=1 and `req`=0, the outputs are `index`=0, `hit`=0 and `empty`=1.
- R6: Requests in a lower byte group have no effect on `index` while any bit of a higher group is set.
- R7: `index[4:3]` holds the group number of the winning request: 3 for bits 31..24, 2 for bits 23..16, 1 for bits 15..8 and 0 for bits 7..0. `index[2:0]` holds the position of the winner within its group.
- R8: With `en`=1 and all 32 requests set, `index`=31, `hit`=1 and `empty`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req | input | 32 | Request vector; bit 31 has the highest priority |
| en | input | 1 | Global enable; feeds the slice for the top group |
| index | output | 5 | Position of the highest set request |
| hit | output | 1 | High when the block is enabled and some request is set |
| empty | output | 1 | High when the block is enabled and no request is set |

## Verification
Every result is combinational, so it is due in the same cycle as its stimulus. No result lags its stimulus by a register.

The bench changes `req` and `en` just after a rising clock edge. It compares the outputs at the following falling edge, half a period later, when the ripple through the slice chain has settled.

The expected values come from a scan that starts at bit 31 and moves down. The group number and the in-group position of the expected index are also checked on their own. This keeps the chaining order and the upper-bit wiring separate from the overall match.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int unsigned DEF_SLICE_W = 8;
  localparam int unsigned DEF_SLICES  = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pe_slice.sv
module pe_slice #(
  parameter int unsigned W = pe_pkg::DEF_SLICE_W,
  localparam int unsigned IW = pe_pkg::idx_width(W)
) (
  input  logic [W-1:0]  req,
  input  logic          en,
  output logic [IW-1:0] idx,
  output logic          hit,
  output logic          empty
);
  logic          any_set;
  logic [IW-1:0] top_pos;

  // Ascending scan: the last set bit seen is the highest, so it wins.
  always_comb begin
    top_pos = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) top_pos = IW'(i);
    end
  end

  assign any_set = |req;
  assign idx     = en ? top_pos : '0;
  assign hit     = en & any_set;
  assign empty   = en & ~any_set;

  always_comb begin
    p_hit_empty_excl_r2: assert (!(hit && empty))
      else $error("slice hit and empty both high");
    p_off_quiet_r4: assert (en || (idx == '0 && !hit && !empty))
      else $error("disabled slice not quiet");
    p_idx_is_set_r1: assert (!hit || req[idx])
      else $error("slice index points at a clear bit");
    p_nothing_above_r1: assert (!hit || ((req >> idx) == W'(1)))
      else $error("slice ignored a higher request");
  end
endmodule

// File: rtl/pe_merge.sv
module pe_merge #(
  parameter int unsigned SLICES = pe_pkg::DEF_SLICES,
  parameter int unsigned LW     = 3,
  localparam int unsigned GW    = pe_pkg::idx_width(SLICES),
  localparam int unsigned OW    = LW + GW
) (
  input  logic [SLICES*LW-1:0] local_idx,
  input  logic [SLICES-1:0]    slice_hit,
  output logic [OW-1:0]        index,
  output logic                 any_hit
);
  logic [LW-1:0] low_or;
  logic [GW-1:0] grp_or;

  // Disabled slices drive zero, so OR-ing the locals and the group numbers
  // of the hitting slices gives the winner's position.
  always_comb begin
    low_or = '0;
    grp_or = '0;
    for (int k = 0; k < SLICES; k++) begin
      low_or = low_or | local_idx[k*LW +: LW];
      if (slice_hit[k]) grp_or = grp_or | GW'(k);
    end
  end

  assign index   = {grp_or, low_or};
  assign any_hit = |slice_hit;

  always_comb begin
    p_single_group_r6: assert ($onehot0(slice_hit))
      else $error("more than one slice reports a hit");
  end
endmodule

// File: rtl/pe_tree.sv
module pe_tree #(
  parameter int unsigned SLICE_W = pe_pkg::DEF_SLICE_W,
  parameter int unsigned SLICES  = pe_pkg::DEF_SLICES,
  localparam int unsigned N      = SLICE_W * SLICES,
  localparam int unsigned LW     = pe_pkg::idx_width(SLICE_W),
  localparam int unsigned OW     = LW + pe_pkg::idx_width(SLICES)
) (
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [OW-1:0] index,
  output logic          hit,
  output logic          empty
);
  // en_chain[k+1] enables slice k; en_chain[k] is slice k's empty flag.
  logic [SLICES:0]        en_chain;
  logic [SLICES-1:0]      slice_hit;
  logic [SLICES*LW-1:0]   local_idx;

  assign en_chain[SLICES] = en;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    pe_slice #(.W(SLICE_W)) u_slice (
      .req   (req[k*SLICE_W +: SLICE_W]),
      .en    (en_chain[k+1]),
      .idx   (local_idx[k*LW +: LW]),
      .hit   (slice_hit[k]),
      .empty (en_chain[k])
    );
  end

  pe_merge #(.SLICES(SLICES), .LW(LW)) u_merge (
    .local_idx (local_idx),
    .slice_hit (slice_hit),
    .index     (index),
    .any_hit   (hit)
  );

  assign empty = en_chain[0];

  always_comb begin
    p_top_idx_set_r1: assert (!hit || req[index])
      else $error("tree index points at a clear bit");
    p_empty_means_none_r3: assert (!empty || (en && req == '0))
      else $error("empty flag with requests present");
    p_top_excl_r2: assert (!(hit && empty))
      else $error("tree hit and empty both high");
  end
endmodule

// File: tb/pe_tree_test.sv
module pe_tree_test;
  logic        clk = 1'b0;
  logic [31:0] req = '0;
  logic        en  = 1'b0;
  logic [4:0]  index;
  logic        hit;
  logic        empty;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  pe_tree uut (.req(req), .en(en), .index(index), .hit(hit), .empty(empty));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (req=%h en=%0b)", tag, act, exp, req, en);
    end
  endtask

  // Settles inputs after a rising edge and compares at the falling edge.
  task automatic apply(input logic [31:0] r, input logic e);
    int exp_idx = 0;
    bit found = 0;
    @(posedge clk);
    req = r;
    en  = e;
    for (int b = 31; b >= 0; b--) begin
      if (!found && r[b]) begin
        exp_idx = b;
        found   = 1;
      end
    end
    @(negedge clk);
    if (!e) begin
      check("R4 index", int'(index), 0);
      check("R4 hit", int'(hit), 0);
      check("R4 empty", int'(empty), 0);
    end else begin
      check("R1 index", int'(index), exp_idx);
      check("R2 hit", int'(hit), int'(found));
      check("R3 empty", int'(empty), int'(!found));
      check("R7 group", int'(index[4:3]), exp_idx / 8);
      check("R7 local", int'(index[2:0]), exp_idx % 8);
    end
  endtask

  initial begin
    // Quiet start, disabled.
    @(negedge clk);
    check("R4 start index", int'(index), 0);
    check("R4 start hit", int'(hit), 0);
    check("R4 start empty", int'(empty), 0);

    // R5: enabled with no requests.
    apply(32'h0, 1'b1);
    check("R5 empty", int'(empty), 1);

    // R8: all ones.
    apply(32'hFFFF_FFFF, 1'b1);
    check("R8 index", int'(index), 31);

    // Single-hot sweep, enabled and disabled.
    for (int b = 0; b < 32; b++) begin
      apply(32'h1 << b, 1'b1);
      apply(32'h1 << b, 1'b0);
    end

    // R6: a higher group masks every lower pattern.
    for (int g = 1; g < 4; g++) begin
      for (int b = 0; b < 8; b++) begin
        logic [31:0] low_junk;
        low_junk = (32'hFFFF_FFFF >> (32 - 8 * g));
        apply((32'h1 << (8 * g + b)) | low_junk, 1'b1);
        check("R6 masked", int'(index), 8 * g + b);
      end
    end
    apply(32'hFFFF_FFFF, 1'b0);

    // Random multi-hot with varying sparsity.
    for (int t = 0; t < 3000; t++) begin
      logic [31:0] r;
      r = $urandom();
      if (t % 3 == 1) r = r & $urandom();
      if (t % 3 == 2) r = r & $urandom() & $urandom() & $urandom();
      apply(r, (t % 7) != 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule